// File: doc/BRIEF.md
# I/O Virtual Address Table Walker

This block turns a device-issued DMA address into a system page address. Each request carries a 64-bit device address, a read/write flag and the requester's partition number. The block first screens the address. Addresses with a nonzero top nibble fault at once. So does the 32-bit interrupt window when that window is enabled. For the remaining addresses, the block picks one of the two descriptors that belong to the partition.

A descriptor selects one of two modes:
- **Bypass mode** passes the address through as a 4 KiB page.
- **Translated mode** starts a walk of one to five levels of 64-bit big-endian table entries. The entries are fetched through a valid/ready memory read port.

The result is returned with a one-cycle done pulse. It carries:
- a fault flag,
- the page-aligned input address,
- the translated page address,
- the in-page address mask,
- a two-bit permission field.

Only one walk is in flight at a time.

Descriptors sit in a small store of two entries per partition, loaded through a write port. Each descriptor is 64 bits wide and uses this layout (bit 0 is the least significant bit):

| Bits | Field |
|------|-------|
| [4:0] | page-size code |
| [9:5] | table-size code |
| [12:10] | level code |
| [47:16] | table base, given in 4 KiB units |
| 51 | bypass permit |

Top module: `iova_walker`

## Requirements
- R1: A request whose address bits 63:60 are not all zero completes as a fault. Every fault result has fault=1, perm=0, translated address 0, mask all ones, and the unmodified input address as the page address.
- R2: The descriptor used is entry number partition*2 + address bit 59, so the two halves of the address space of one partition can map differently.
- R3: While the 32-bit interrupt window is enabled, addresses 0xFFFF0000 to 0xFFFFFFFF fault. While it is disabled, these addresses are translated normally.
- R4: A descriptor whose level code is above 4 faults. A translated-mode descriptor whose table-size code is 0 faults. A level code of exactly 4 walks five levels.
- R5: A page-size code of 0 selects bypass, but only when descriptor bit 51 is set; otherwise the request faults. A bypass result has perm=3, mask 0xFFF, page address = address with its low 12 bits cleared, and translated address = address AND 0x0003FFFFFFFFF000.
- R6: In translated mode the page shift is page-size code + 11, the per-level index width is table-size code + 8, and the walk reads level code + 1 entries. The first index starts at bit (index width × level code + page shift). Each entry address is the current base ORed with index × 8. The next base is the entry with its low 12 bits cleared.
- R7: A non-final entry whose bits 1:0 are both zero ends the walk with a fault result.
- R8: The final entry's bit 0 grants read and bit 1 grants write. The result reports perm = entry bits 1:0, translated address = entry AND NOT page mask, and mask = 2^shift − 1. The fault flag is set when the requested access is not granted.
- R9: Memory data is big-endian: the most significant byte of an entry arrives in bits 7:0 of the read data.
- R10: A read response that carries the error flag ends the walk with a fault result.
- R11: After reset, req_ready_o is high and rsp_valid_o and mem_req_valid_o are low. rsp_valid_o is a single-cycle pulse. req_ready_o stays low while a walk is in flight. A result that needs no memory read appears in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Descriptor write strobe |
| desc_idx_i | input | DIDX_W | Descriptor entry written |
| desc_wdata_i | input | 64 | Descriptor value |
| msi32_en_i | input | 1 | 32-bit interrupt window enable |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_addr_i | input | 64 | Device address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_part_i | input | PART_W | Requester partition |
| rsp_valid_o | output | 1 | Result done pulse |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_perm_o | output | 2 | Permission bits (bit 0 read, bit 1 write) |
| rsp_iova_o | output | 64 | Page-aligned input address |
| rsp_xaddr_o | output | 64 | Translated page address |
| rsp_mask_o | output | 64 | In-page address mask |
| mem_req_valid_o | output | 1 | Entry fetch request |
| mem_req_ready_i | input | 1 | Memory accepts fetch |
| mem_req_addr_o | output | 64 | Entry byte address |
| mem_rsp_valid_i | input | 1 | Fetch data valid |
| mem_rsp_data_i | input | 64 | Fetch data, big-endian |
| mem_rsp_err_i | input | 1 | Fetch error |

## Verification
Results that need no table read are due on the first falling edge after the accepting rising edge. For those vectors the bench counts the edges and flags any other latency. A walk takes at least two cycles per level, plus any cycles the memory model holds ready low. For walks the bench therefore polls rsp_valid_o on falling edges within a bounded window and compares every result field when the pulse is seen. On the falling edge after each result it also confirms that the pulse has dropped.

// File: rtl/iova_walker_pkg.sv
package iova_walker_pkg;

  localparam logic [63:0] BYP_XMASK = 64'h0003_FFFF_FFFF_F000;
  localparam int unsigned BYP_OK_BIT = 51;

  typedef enum logic [1:0] {K_FAULT, K_BYPASS, K_WALK} xw_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} xw_state_e;

  typedef struct packed {
    logic        byp_ok;
    logic [31:0] base;
    logic [2:0]  lvl;
    logic [4:0]  tsz;
    logic [4:0]  psz;
  } xw_desc_t;

  function automatic xw_desc_t desc_unpack(input logic [63:0] raw);
    xw_desc_t d;
    d.psz    = raw[4:0];
    d.tsz    = raw[9:5];
    d.lvl    = raw[12:10];
    d.base   = raw[47:16];
    d.byp_ok = raw[BYP_OK_BIT];
    return d;
  endfunction

  function automatic logic [63:0] bswap64(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/iova_walker_desc_store.sv
module iova_walker_desc_store #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [63:0]   wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [63:0]   rdata_o
);
  logic [63:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        ent_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))  ent_q[g] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[ridx_i];
endmodule

// File: rtl/iova_walker_classify.sv
module iova_walker_classify
  import iova_walker_pkg::*;
#(
  parameter int MAX_LVL = 4
) (
  input  logic [63:0] addr_i,
  input  logic        msi32_en_i,
  input  logic [63:0] desc_i,
  output xw_kind_e    kind_o,
  output logic [63:0] base_o,
  output logic [2:0]  lvl_o,
  output logic [5:0]  tbl_sh_o,
  output logic [5:0]  pg_sh_o,
  output logic [7:0]  first_sh_o
);
  xw_desc_t d;
  logic     top_bad, in_msi;

  assign d        = desc_unpack(desc_i);
  assign top_bad  = |addr_i[63:60];
  assign in_msi   = msi32_en_i && (addr_i[63:16] == 48'h0000_0000_FFFF);
  assign base_o   = {20'b0, d.base, 12'b0};
  assign lvl_o    = d.lvl;
  assign tbl_sh_o = 6'(d.tsz) + 6'd8;
  assign pg_sh_o  = 6'(d.psz) + 6'd11;
  assign first_sh_o = 8'(8'(tbl_sh_o) * 8'(d.lvl)) + 8'(pg_sh_o);

  always_comb begin
    kind_o = K_WALK;
    if (top_bad || in_msi)                  kind_o = K_FAULT;
    else if (32'(d.lvl) > MAX_LVL)          kind_o = K_FAULT;
    else if (d.psz == '0)                   kind_o = d.byp_ok ? K_BYPASS : K_FAULT;
    else if (d.tsz == '0)                   kind_o = K_FAULT;
  end
endmodule

// File: rtl/iova_walker_engine.sv
module iova_walker_engine
  import iova_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  xw_kind_e    kind_i,
  input  logic [63:0] addr_i,
  input  logic        write_i,
  input  logic [63:0] base_i,
  input  logic [2:0]  lvl_i,
  input  logic [5:0]  tbl_sh_i,
  input  logic [5:0]  pg_sh_i,
  input  logic [7:0]  first_sh_i,
  output logic        busy_o,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [1:0]  rsp_perm_o,
  output logic [63:0] rsp_iova_o,
  output logic [63:0] rsp_xaddr_o,
  output logic [63:0] rsp_mask_o,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [63:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [63:0] mem_rsp_data_i,
  input  logic        mem_rsp_err_i
);
  xw_state_e   state_q;
  logic [63:0] addr_q, base_q;
  logic        wr_q;
  logic [7:0]  sh_q;
  logic [5:0]  tbl_q, pg_q;
  logic [2:0]  left_q;
  logic [63:0] idx, ent, pmask;

  assign idx   = (addr_q >> sh_q) & ((64'd1 << tbl_q) - 64'd1);
  assign ent   = bswap64(mem_rsp_data_i);
  assign pmask = (64'd1 << pg_q) - 64'd1;

  assign busy_o          = (state_q != ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_ISSUE);
  assign mem_req_addr_o  = base_q | (idx << 3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      base_q      <= '0;
      wr_q        <= 1'b0;
      sh_q        <= '0;
      tbl_q       <= '0;
      pg_q        <= '0;
      left_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_perm_o  <= '0;
      rsp_iova_o  <= '0;
      rsp_xaddr_o <= '0;
      rsp_mask_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q <= addr_i;
          wr_q   <= write_i;
          unique case (kind_i)
            K_WALK: begin
              base_q  <= base_i;
              sh_q    <= first_sh_i;
              tbl_q   <= tbl_sh_i;
              pg_q    <= pg_sh_i;
              left_q  <= lvl_i;
              state_q <= ST_ISSUE;
            end
            K_BYPASS: begin
              rsp_valid_o <= 1'b1;
              rsp_fault_o <= 1'b0;
              rsp_perm_o  <= 2'b11;
              rsp_iova_o  <= addr_i & ~64'hFFF;
              rsp_xaddr_o <= addr_i & BYP_XMASK;
              rsp_mask_o  <= 64'hFFF;
            end
            default: begin
              rsp_valid_o <= 1'b1;
              rsp_fault_o <= 1'b1;
              rsp_perm_o  <= '0;
              rsp_iova_o  <= addr_i;
              rsp_xaddr_o <= '0;
              rsp_mask_o  <= '1;
            end
          endcase
        end
        ST_ISSUE: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i || (left_q != '0 && ent[1:0] == 2'b00)) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= 1'b1;
            rsp_perm_o  <= '0;
            rsp_iova_o  <= addr_q;
            rsp_xaddr_o <= '0;
            rsp_mask_o  <= '1;
            state_q     <= ST_IDLE;
          end else if (left_q == '0) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= wr_q ? ~ent[1] : ~ent[0];
            rsp_perm_o  <= ent[1:0];
            rsp_iova_o  <= addr_q & ~pmask;
            rsp_xaddr_o <= ent & ~pmask;
            rsp_mask_o  <= pmask;
            state_q     <= ST_IDLE;
          end else begin
            base_q  <= {ent[63:12], 12'b0};
            sh_q    <= sh_q - 8'(tbl_q);
            left_q  <= left_q - 3'd1;
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iova_walker_pkg::*;
#(
  parameter int NUM_PART = 4,
  parameter int MAX_LVL  = 4,
  localparam int PART_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
  localparam int NUM_DESC = 2 * NUM_PART,
  localparam int DIDX_W   = PART_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_we_i,
  input  logic [DIDX_W-1:0] desc_idx_i,
  input  logic [63:0]       desc_wdata_i,
  input  logic              msi32_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_addr_i,
  input  logic              req_write_i,
  input  logic [PART_W-1:0] req_part_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [1:0]        rsp_perm_o,
  output logic [63:0]       rsp_iova_o,
  output logic [63:0]       rsp_xaddr_o,
  output logic [63:0]       rsp_mask_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [63:0]       mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i,
  input  logic              mem_rsp_err_i
);
  logic [DIDX_W-1:0] ridx;
  logic [63:0]       desc_raw, base;
  xw_kind_e          kind;
  logic [2:0]        lvl;
  logic [5:0]        tbl_sh, pg_sh;
  logic [7:0]        first_sh;
  logic              busy, accept;

  assign ridx        = {req_part_i, req_addr_i[59]};
  assign req_ready_o = ~busy;
  assign accept      = req_valid_i & ~busy;

  iova_walker_desc_store #(.DEPTH(NUM_DESC)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (desc_we_i),
    .widx_i  (desc_idx_i),
    .wdata_i (desc_wdata_i),
    .ridx_i  (ridx),
    .rdata_o (desc_raw)
  );

  iova_walker_classify #(.MAX_LVL(MAX_LVL)) u_class (
    .addr_i     (req_addr_i),
    .msi32_en_i (msi32_en_i),
    .desc_i     (desc_raw),
    .kind_o     (kind),
    .base_o     (base),
    .lvl_o      (lvl),
    .tbl_sh_o   (tbl_sh),
    .pg_sh_o    (pg_sh),
    .first_sh_o (first_sh)
  );

  iova_walker_engine u_eng (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (accept),
    .kind_i          (kind),
    .addr_i          (req_addr_i),
    .write_i         (req_write_i),
    .base_i          (base),
    .lvl_i           (lvl),
    .tbl_sh_i        (tbl_sh),
    .pg_sh_i         (pg_sh),
    .first_sh_i      (first_sh),
    .busy_o          (busy),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_perm_o      (rsp_perm_o),
    .rsp_iova_o      (rsp_iova_o),
    .rsp_xaddr_o     (rsp_xaddr_o),
    .rsp_mask_o      (rsp_mask_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_rsp_err_i   (mem_rsp_err_i)
  );
endmodule

// File: rtl/iova_walker_checker.sv
module iova_walker_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_fault_o,
  input logic [1:0]  rsp_perm_o,
  input logic [63:0] rsp_xaddr_o,
  input logic [63:0] rsp_mask_o,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [63:0] mem_req_addr_o
);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_accept_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_valid_o || !req_ready_o));

  p_idle_no_fetch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o);

  p_fetch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_fetch_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000));

  p_page_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ((rsp_xaddr_o & rsp_mask_o) == 64'd0));

  p_grant_perm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_perm_o != 2'b00));
endmodule

bind iova_walker iova_walker_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_perm_o      (rsp_perm_o),
  .rsp_xaddr_o     (rsp_xaddr_o),
  .rsp_mask_o      (rsp_mask_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/iova_walker_bench.sv
module iova_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 1'b0;
  logic [2:0]  desc_idx = '0;
  logic [63:0] desc_wdata = '0;
  logic        msi32_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_part = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_perm;
  logic [63:0] rsp_iova, rsp_xaddr, rsp_mask;
  logic        mem_req_valid;
  logic        mem_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  iova_walker u_iova_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_we_i(desc_we), .desc_idx_i(desc_idx), .desc_wdata_i(desc_wdata),
    .msi32_en_i(msi32_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_part_i(req_part),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_perm_o(rsp_perm),
    .rsp_iova_o(rsp_iova), .rsp_xaddr_o(rsp_xaddr), .rsp_mask_o(rsp_mask),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .mem_rsp_err_i(mem_rsp_err)
  );

  // Memory model: logical entries, delivered big-endian; error above 0x900000..0x9FFFFF
  logic [63:0] mem_q [logic [63:0]];

  function automatic logic [63:0] swap(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  always @(negedge clk) mem_ready <= ~mem_ready;

  always @(posedge clk) begin
    if (mem_req_valid && mem_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= swap(mem_q.exists(mem_req_addr) ? mem_q[mem_req_addr] : 64'd0);
      mem_rsp_err   <= (mem_req_addr >= 64'h90_0000) && (mem_req_addr < 64'hA0_0000);
    end else begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
    end
  end

  typedef struct packed {
    logic [63:0] addr;
    logic        wr;
    logic [1:0]  part;
    logic        msi;
    logic        imm;
    logic        fault;
    logic [1:0]  perm;
    logic [63:0] iova;
    logic [63:0] xaddr;
    logic [63:0] mask;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R6 R9: single level read
    '{64'h5123, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 64'h5000, 64'hABCD_E000, 64'hFFF, 8'd6},
    // R8: write granted
    '{64'h5123, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 64'h5000, 64'hABCD_E000, 64'hFFF, 8'd8},
    // R8: read on read-only entry
    '{64'h6000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 64'h6000, 64'h1234_5000, 64'hFFF, 8'd8},
    // R8: write on read-only entry -> access fault
    '{64'h6000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 64'h6000, 64'h1234_5000, 64'hFFF, 8'd8},
    // R2 R6: second descriptor, two levels
    '{64'h0800_0000_0060_70AB, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 64'h0800_0000_0060_7000, 64'hF0_0000_7000, 64'hFFF, 8'd2},
    // R7: invalid indirect entry
    '{64'h0800_0000_0080_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 64'h0800_0000_0080_0000, 64'h0, ONES, 8'd7},
    // R5: bypass
    '{64'h0123_4567_89AB_CDEF, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 64'h0123_4567_89AB_C000, 64'h0003_4567_89AB_C000, 64'hFFF, 8'd5},
    // R5: bypass not permitted
    '{64'h0800_0000_0000_1000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 64'h0800_0000_0000_1000, 64'h0, ONES, 8'd5},
    // R1: top nibble 1
    '{64'h1000_0000_0000_0000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 64'h1000_0000_0000_0000, 64'h0, ONES, 8'd1},
    // R1: top bit 63
    '{64'h8000_0000_0000_1000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 64'h8000_0000_0000_1000, 64'h0, ONES, 8'd1},
    // R3: interrupt window enabled
    '{64'hFFFF_0010, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 64'hFFFF_0010, 64'h0, ONES, 8'd3},
    // R3: window disabled -> translated
    '{64'hFFFF_0010, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 64'hFFFF_0000, 64'h7777_7000, 64'hFFF, 8'd3},
    // R4: level code 5
    '{64'h5000, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 2'd0, 64'h5000, 64'h0, ONES, 8'd4},
    // R4: table-size code 0
    '{64'h0800_0000_0000_5000, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 2'd0, 64'h0800_0000_0000_5000, 64'h0, ONES, 8'd4},
    // R10: read error
    '{64'h5000, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 64'h5000, 64'h0, ONES, 8'd10},
    // R6: 2 MiB page, 10-bit index
    '{64'h0800_0000_1234_5678, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd3, 64'h0800_0000_1220_0000, 64'h4060_0000, 64'h1F_FFFF, 8'd6}
  };

  task automatic check(input bit ok, input string what, input int rq,
                       input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wdesc(input logic [2:0] idx, input logic [63:0] val);
    @(negedge clk);
    desc_we = 1'b1; desc_idx = idx; desc_wdata = val;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic run(input vec_t v);
    int lat;
    logic [255:0] act, exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = v.addr; req_write = v.wr; req_part = v.part; msi32_en = v.msi;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    act = {61'd0, rsp_fault, rsp_perm, rsp_iova, rsp_xaddr, rsp_mask};
    exp = {61'd0, v.fault, v.perm, v.iova, v.xaddr, v.mask};
    check(rsp_valid && act == exp, "result", int'(v.req), act, exp);
    // R11: immediate results one cycle after acceptance
    if (v.imm) check(lat == 1, "latency", 11, 256'(lat), 256'd1);
    @(negedge clk);
    check(!rsp_valid, "done pulse width", 11, 256'(rsp_valid), 256'd0);
  endtask

  initial begin
    vec_t v5;
    mem_q[64'h10_0028] = 64'h0000_0000_ABCD_E003;
    mem_q[64'h10_0030] = 64'h0000_0000_1234_5001;
    mem_q[64'h10_0F80] = 64'h0000_0000_7777_7003;
    mem_q[64'h20_0018] = 64'h0000_0000_0030_0003;
    mem_q[64'h30_0038] = 64'h0000_00F0_0000_7002;
    mem_q[64'h20_0020] = 64'h0000_0000_0040_0000;
    mem_q[64'h40_0488] = 64'h0000_0000_4060_0003;
    mem_q[64'h50_0008] = 64'h0000_0000_0051_0001;
    mem_q[64'h51_0008] = 64'h0000_0000_0052_0002;
    mem_q[64'h52_0008] = 64'h0000_0000_0053_0003;
    mem_q[64'h53_0008] = 64'h0000_0000_0054_0001;
    mem_q[64'h54_0008] = 64'h0000_0000_0CAF_E003;

    repeat (3) @(negedge clk);
    // R11: reset state
    check(req_ready === 1'b1, "reset ready", 11, 256'(req_ready), 256'd1);
    check(rsp_valid === 1'b0, "reset rsp_valid", 11, 256'(rsp_valid), 256'd0);
    check(mem_req_valid === 1'b0, "reset mem_req_valid", 11, 256'(mem_req_valid), 256'd0);
    rst_n = 1'b1;

    wdesc(3'd0, 64'h0000_0000_0100_0021);  // lvl0 psz1 tsz1 base 0x100
    wdesc(3'd1, 64'h0000_0000_0200_0421);  // lvl1 psz1 tsz1 base 0x200
    wdesc(3'd2, 64'h0008_0000_0000_0000);  // bypass permitted
    wdesc(3'd3, 64'h0000_0000_0000_0000);  // bypass denied
    wdesc(3'd4, 64'h0000_0000_0100_1421);  // lvl5
    wdesc(3'd5, 64'h0000_0000_0100_0001);  // tsz0
    wdesc(3'd6, 64'h0000_0000_0900_0021);  // base in error range
    wdesc(3'd7, 64'h0000_0000_0400_004A);  // psz10 tsz2

    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R4 R6: level code 4 walks five levels
    wdesc(3'd4, 64'h0000_0000_0500_1021);
    v5 = '{64'h0001_0080_4020_1000, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd3,
           64'h0001_0080_4020_1000, 64'h0CAF_E000, 64'hFFF, 8'd4};
    run(v5);

    // R11: ready low while a walk is in flight
    @(negedge clk);
    req_addr = 64'h5123; req_write = 1'b0; req_part = 2'd0; msi32_en = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "busy during walk", 11, 256'(req_ready), 256'd0);
    while (!rsp_valid) @(negedge clk);
    check(rsp_xaddr == 64'hABCD_E000, "walk after busy", 6, rsp_xaddr, 64'hABCD_E000);

    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_run++;
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule